// File: doc/BRIEF.md
# SPI Clock Divider Encoder

This block converts a requested integer clock division ratio into the mantissa/exponent pair that an extended SPI clock prescaler uses. The achieved ratio is mantissa × 2^exponent. The block picks the smallest ratio that is not below the request, so the serial clock never runs faster than the one the caller asked for. The mantissa is 4 bits wide and the exponent is 3 bits wide.

Ratios below 16 pass through unchanged with a zero exponent. For larger ratios the block works in three steps. It first takes the exponent from the position of the leading one. It then rounds the ratio up to a multiple of 2^exponent. Finally it takes the exponent again, because the rounding carry can move the leading one by one place. The block also packs the pair into an 8-bit prescale field. If the final exponent does not fit in 3 bits, the block raises an error flag instead of giving a setting.

Requests arrive on a valid/ready port. A request is taken in any cycle where `in_valid` and `in_ready` are both high. `in_ready` then stays low for the next two cycles, and any request offered during those cycles is held off. The result appears for exactly one cycle, three cycles after the accepting cycle. The result port has no back-pressure, so the consumer must capture the result in that cycle.

Top module: `spidiv_enc`

## Requirements
- R1: While reset is active and in the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: A request is accepted in a cycle where `in_valid` and `in_ready` are both 1. In the two cycles that follow, `in_ready` is 0.
- R3: The result of a request accepted in cycle n is presented with `out_valid` = 1 in cycle n+3 only. `out_valid` is 0 in cycle n+4.
- R4: For a ratio d with 1 ≤ d ≤ 15, `out_spr` = d, `out_sppr` = 0 and `out_err` = 0.
- R5: A ratio of 0 gives the same result as a ratio of 1.
- R6: For d ≥ 16 with no error, `out_spr` lies in 8..15. Among all such pairs, `out_spr`·2^`out_sppr` is the smallest product that is ≥ d.
- R7: When no pair with an exponent of at most 7 reaches d (d > 1920), `out_err` = 1 and `out_spr`, `out_sppr` and `out_field` are all 0.
- R8: `out_field` holds the mantissa in bits [3:0], exponent bit 0 in bit 4, exponent bits [2:1] in bits [7:6], and 0 in bit 5.
- R9: A divider offered while `in_ready` is 0 is not taken. The result that follows belongs to the request that was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request |
| in_div | input | DIV_W (11) | Requested division ratio |
| out_valid | output | 1 | Result valid for this cycle only |
| out_spr | output | 4 | Mantissa of the chosen ratio |
| out_sppr | output | 3 | Exponent of the chosen ratio |
| out_field | output | 8 | Packed prescale field |
| out_err | output | 1 | Ratio cannot be reached with a 3-bit exponent |

## Verification
The latency and pulse properties rely on the caller keeping `in_valid` low during reset. They also rely on there being no way to accept a second request until `in_ready` returns. The bench drives every 11-bit divider value once. After each acceptance it keeps `in_valid` high with a different, unrelated divider for the two blocked cycles. It drops `in_valid` before `in_ready` returns, so exactly one request is in flight whenever a result is checked.

// File: rtl/spidiv_pkg.sv
package spidiv_pkg;
  localparam int MANT_W  = 4;
  localparam int EXP_W   = 3;
  localparam int FIELD_W = 8;

  typedef struct packed {
    logic [MANT_W-1:0] spr;
    logic [EXP_W-1:0]  sppr;
    logic              err;
  } enc_res_t;
endpackage

// File: rtl/spidiv_msb.sv
// Position of the leading one, counted from 1; zero input gives 0.
module spidiv_msb #(
  parameter int W  = 12,
  localparam int PW = $clog2(W + 1)
) (
  input  logic [W-1:0]  val,
  output logic [PW-1:0] pos
);
  always_comb begin
    pos = '0;
    for (int i = 0; i < W; i++) begin
      if (val[i]) pos = PW'(i + 1);
    end
  end
endmodule

// File: rtl/spidiv_pack.sv
// Places mantissa and exponent into the prescale field layout.
module spidiv_pack
  import spidiv_pkg::*;
(
  input  logic [MANT_W-1:0]  spr,
  input  logic [EXP_W-1:0]   sppr,
  output logic [FIELD_W-1:0] field
);
  always_comb begin
    field      = '0;
    field[3:0] = spr;
    field[4]   = sppr[0];
    field[7:6] = sppr[2:1];
  end
endmodule

// File: rtl/spidiv_enc.sv
module spidiv_enc
  import spidiv_pkg::*;
#(
  parameter int DIV_W = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [DIV_W-1:0]   in_div,
  output logic               out_valid,
  output logic [MANT_W-1:0]  out_spr,
  output logic [EXP_W-1:0]   out_sppr,
  output logic [FIELD_W-1:0] out_field,
  output logic               out_err
);
  localparam int RW  = DIV_W + 1;
  localparam int PW1 = $clog2(DIV_W + 1);
  localparam int PW2 = $clog2(RW + 1);
  localparam logic [PW1-1:0] MANT_P1 = PW1'(MANT_W);
  localparam logic [PW2-1:0] MANT_P2 = PW2'(MANT_W);
  localparam logic [PW2-1:0] EXP_MAX = PW2'((1 << EXP_W) - 1);

  logic acc;
  logic s1_v, s2_v;
  logic [DIV_W-1:0] s1_div;
  logic [PW1-1:0]   s1_exp;
  logic [RW-1:0]    s2_rnd;

  assign in_ready = !(s1_v || s2_v);
  assign acc      = in_valid && in_ready;

  // Stage 1: clamp zero, first exponent estimate.
  logic [DIV_W-1:0] div_c;
  logic [PW1-1:0]   pos1, exp1;
  assign div_c = (in_div == '0) ? DIV_W'(1) : in_div;

  spidiv_msb #(.W(DIV_W)) u_msb1 (.val(div_c), .pos(pos1));
  assign exp1 = (pos1 > MANT_P1) ? (pos1 - MANT_P1) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v   <= 1'b0;
      s1_div <= '0;
      s1_exp <= '0;
    end else begin
      s1_v <= acc;
      if (acc) begin
        s1_div <= div_c;
        s1_exp <= exp1;
      end
    end
  end

  // Stage 2: round up to a multiple of 2^exponent.
  logic [RW-1:0] mask, rnd;
  always_comb begin
    mask = (RW'(1) << s1_exp) - RW'(1);
    rnd  = (RW'(s1_div) + mask) & ~mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_v   <= 1'b0;
      s2_rnd <= '0;
    end else begin
      s2_v <= s1_v;
      if (s1_v) s2_rnd <= rnd;
    end
  end

  // Stage 3: final exponent, mantissa, range check, packing.
  logic [PW2-1:0]     pos2, exp2;
  logic [RW-1:0]      shifted;
  enc_res_t           res;
  logic [FIELD_W-1:0] field_c;

  spidiv_msb #(.W(RW)) u_msb2 (.val(s2_rnd), .pos(pos2));

  always_comb begin
    exp2    = (pos2 > MANT_P2) ? (pos2 - MANT_P2) : '0;
    shifted = s2_rnd >> exp2;
    res.err = (exp2 > EXP_MAX);
    if (res.err) begin
      res.spr  = '0;
      res.sppr = '0;
    end else begin
      res.spr  = shifted[MANT_W-1:0];
      res.sppr = exp2[EXP_W-1:0];
    end
  end

  spidiv_pack u_pack (.spr(res.spr), .sppr(res.sppr), .field(field_c));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_spr   <= '0;
      out_sppr  <= '0;
      out_field <= '0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= s2_v;
      if (s2_v) begin
        out_spr   <= res.spr;
        out_sppr  <= res.sppr;
        out_field <= field_c;
        out_err   <= res.err;
      end
    end
  end

  // R2
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc) |-> !in_ready);
  // R3
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(acc, 3));
  // R3
  pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  // R7
  err_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> (out_spr == '0 && out_sppr == '0 && out_field == '0));
  // R6
  norm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_err && out_sppr != '0) |-> out_spr[MANT_W-1]);
  // R8
  gap_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_field[5]);
endmodule

// File: tb/spidiv_enc_bench.sv
module spidiv_enc_bench;
  localparam int PERIOD = 10;
  localparam int DIV_W  = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [DIV_W-1:0] in_div = '0;
  logic in_ready, out_valid, out_err;
  logic [3:0] out_spr;
  logic [2:0] out_sppr;
  logic [7:0] out_field;

  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  spidiv_enc #(.DIV_W(DIV_W)) u_spidiv_enc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_div(in_div), .out_valid(out_valid), .out_spr(out_spr),
    .out_sppr(out_sppr), .out_field(out_field), .out_err(out_err));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Arithmetic model from R4..R7: smallest normalised product not below d.
  task automatic model(input int d, output int m, output int e, output int er);
    int dd;
    bit found;
    dd = (d == 0) ? 1 : d;
    m = 0; e = 0; er = 0; found = 0;
    if (dd < 16) begin
      m = dd; found = 1;
    end else begin
      for (int ee = 1; ee <= 7 && !found; ee++)
        for (int mm = 8; mm <= 15 && !found; mm++)
          if ((mm << ee) >= dd) begin m = mm; e = ee; found = 1; end
    end
    if (!found) er = 1;
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int m, e, er, fexp;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
    chk(in_ready == 1'b1, "R1 in_ready in reset", in_ready, 1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);

    for (int d = 0; d < (1 << DIV_W); d++) begin
      model(d, m, e, er);
      // cycle n: offer and accept
      in_valid = 1'b1;
      in_div   = DIV_W'(d);
      chk(in_ready == 1'b1, "R2 ready before accept", in_ready, 1);
      @(negedge clk);
      // cycle n+1: blocked, offer an unrelated divider (R9)
      chk(in_ready == 1'b0, "R2 ready low n+1", in_ready, 0);
      chk(out_valid == 1'b0, "R3 no early result n+1", out_valid, 0);
      in_div = DIV_W'(d ^ 11'h5A5);
      @(negedge clk);
      chk(in_ready == 1'b0, "R2 ready low n+2", in_ready, 0);
      chk(out_valid == 1'b0, "R3 no early result n+2", out_valid, 0);
      @(negedge clk);
      // cycle n+3: result
      in_valid = 1'b0;
      chk(out_valid == 1'b1, "R3 result valid n+3", out_valid, 1);
      chk(int'(out_err) == er, (er != 0) ? "R7 error flag" : "R6 error flag", out_err, er);
      chk(int'(out_spr) == m,
          (d == 0) ? "R5 spr for zero" : (d < 16) ? "R4 spr" : "R6 spr", out_spr, m);
      chk(int'(out_sppr) == e, (d < 16) ? "R4 sppr" : "R6 sppr", out_sppr, e);
      // R8 packing: spr [3:0], sppr[0] at 4, bit 5 zero, sppr[2:1] at [7:6]
      fexp = er ? 0 : (m | ((e & 1) << 4) | ((e >> 1) << 6));
      chk(int'(out_field) == fexp, er ? "R7 field blank" : "R8 field", out_field, fexp);
      @(negedge clk);
      // cycle n+4: pulse over, blocked offers were not taken (R9)
      chk(out_valid == 1'b0, "R3 one-cycle pulse", out_valid, 0);
      @(negedge clk);
      chk(out_valid == 1'b0, "R9 no result from blocked offer", out_valid, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule